// File: doc/BRIEF.md
# Configuration Flag Patch and Image Checksum Sequencer

This block runs a short, fixed maintenance sequence against a word-addressed
non-volatile store. A one-cycle start pulse makes it fetch the configuration
word at address 10. When bit 1 of that word is set, the block writes the word
back with only that bit cleared. It then re-reads the whole image, forms a new
16-bit seal, and stores the seal in the top word. When bit 1 is already clear,
the block leaves the store untouched and finishes at once.

The store is reached through a simple word port. A request is held, with its
address, direction and write data, until the port acknowledges it. The port
may flag an error together with the acknowledge. The serial protocol and the
storage device sit outside the block. When the sequence ends the block pulses
`done`, and it holds four results until the next start: whether a patch was
made, whether the run aborted, the seal value that was replaced, and the seal
value that was written.

Top module: `eep_patch_seq`

## Requirements
- R1: After synchronous reset, `done`, `mem_req`, `patched`, `error`, `old_cksum` and `new_cksum` are all 0.
- R2: The first access after an accepted start is a read (`mem_we`=0) of word address 10.
- R3: If bit 1 (mask 0x0002) of the word read is 0, no write is issued. The run then ends after that single access, with `patched`=0, `error`=0 and both checksum outputs 0.
- R4: If bit 1 is 1, the next access writes word 10 with bit 1 cleared and every other bit unchanged.
- R5: After that write, words 0 to 2^ADDR_W−2 are read. Their 16-bit wrapping sum S includes the rewritten word 10. The value (0xBABA − S) mod 2^16 is then written to word 2^ADDR_W−1. The patch run therefore issues 2^ADDR_W+3 accesses in total.
- R6: The top word is read before it is overwritten. `old_cksum` reports its prior content and `new_cksum` reports the value written. `patched` is 1 after a completed patch run.
- R7: Only one access is outstanding at a time. `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. It is low in the cycle after the acknowledge.
- R8: An acknowledge that carries `mem_err` ends the run. No further access is issued, and `done` and `error` are raised with `patched`=0.
- R9: A start pulse that arrives while a run is in progress is ignored. It causes no extra access and no extra `done`.
- R10: `done` is a one-cycle pulse. The result outputs keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (pulse, accepted when idle) |
| mem_req | output | 1 | Word access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete (one cycle) |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| done | output | 1 | Sequence finished (one cycle) |
| patched | output | 1 | The flag was cleared and a new seal was written |
| error | output | 1 | The sequence aborted on a port error |
| old_cksum | output | 16 | Seal word content before the rewrite |
| new_cksum | output | 16 | Seal word written |

## Verification
The bench runs an image whose summed words wrap past 16 bits. A design that dropped the carry handling, or subtracted in the wrong order, would write a seal that fails the whole-image check. It reruns an image that was already patched, to confirm that a clear flag leaves the store untouched; a design that tested the wrong bit would rewrite it. A start pulse is injected mid-run, which a design without idle gating would answer with a second read of word 10 and an extra `done`. Errors are injected on the first access and in the middle of the summing pass, where a faulty abort would keep issuing accesses or would still overwrite the top word.

// File: rtl/eep_patch_pkg.sv
package eep_patch_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_CFG,
        PH_WR_CFG,
        PH_RD_SUM,
        PH_RD_OLD,
        PH_WR_CK
    } phase_e;

    typedef struct packed {
        logic  patched;
        logic  error;
        word_t old_ck;
        word_t new_ck;
    } result_t;

    function automatic word_t drop_bit(input word_t w, input int pos);
        word_t m;
        m = word_t'(1) << pos;
        return w & ~m;
    endfunction

    function automatic word_t seal_of(input word_t seed, input word_t sum);
        return seed - sum;
    endfunction

endpackage

// File: rtl/eep_cksum_acc.sv
module eep_cksum_acc
    import eep_patch_pkg::*;
#(
    parameter word_t SEED = 16'hBABA
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  add,
    input  word_t val,
    output word_t seal
);
    word_t sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr) sum_q <= '0;
        else if (add)   sum_q <= sum_q + val;
    end

    assign seal = seal_of(SEED, sum_q);

    AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> seal == SEED) else $error("seal after clear");  // R5
endmodule

// File: rtl/eep_word_port.sv
module eep_word_port
    import eep_patch_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  word_t             ld_wdata,
    output logic              fin,
    output logic              fin_err,
    output word_t             rd_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  word_t             mem_rdata
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            pend      <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            if (mem_req && mem_ack) begin
                mem_req <= 1'b0;
            end else if (pend) begin
                mem_req <= 1'b1;
                pend    <= 1'b0;
            end
            if (ld) begin
                mem_we    <= ld_we;
                mem_addr  <= ld_addr;
                mem_wdata <= ld_wdata;
                pend      <= 1'b1;
            end
        end
    end

    assign fin     = mem_req && mem_ack && !mem_err;
    assign fin_err = mem_req && mem_ack && mem_err;
    assign rd_word = mem_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)) else $error("req hold");  // R7
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req) else $error("req gap");  // R7
endmodule

// File: rtl/eep_patch_seq.sv
module eep_patch_seq
    import eep_patch_pkg::*;
#(
    parameter int    ADDR_W   = 6,
    parameter int    CFG_ADDR = 10,
    parameter int    FLAG_BIT = 1,
    parameter word_t SEED     = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              patched,
    output logic              error,
    output logic [15:0]       old_cksum,
    output logic [15:0]       new_cksum
);
    localparam int unsigned       DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);

    phase_e            ph, ph_n;
    result_t           res, res_n;
    logic              done_n;
    logic [ADDR_W-1:0] sum_a, sum_a_n;
    logic              ld, ld_we;
    logic [ADDR_W-1:0] ld_addr;
    word_t             ld_wdata;
    logic              fin, fin_err;
    word_t             rd_word;
    logic              acc_clr, acc_add;
    word_t             acc_seal;

    eep_word_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst(rst),
        .ld(ld), .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
        .fin(fin), .fin_err(fin_err), .rd_word(rd_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata)
    );

    eep_cksum_acc #(.SEED(SEED)) u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
        .val(rd_word), .seal(acc_seal)
    );

    always_comb begin
        ph_n     = ph;
        res_n    = res;
        done_n   = 1'b0;
        sum_a_n  = sum_a;
        ld       = 1'b0;
        ld_we    = 1'b0;
        ld_addr  = '0;
        ld_wdata = '0;
        acc_clr  = 1'b0;
        acc_add  = 1'b0;
        if (ph == PH_IDLE) begin
            if (start) begin
                res_n   = '0;
                ld      = 1'b1;
                ld_addr = CFG_A;
                ph_n    = PH_RD_CFG;
            end
        end else if (fin_err) begin
            res_n.error = 1'b1;
            done_n      = 1'b1;
            ph_n        = PH_IDLE;
        end else if (fin) begin
            case (ph)
                PH_RD_CFG: begin
                    if (rd_word[FLAG_BIT]) begin
                        ld       = 1'b1;
                        ld_we    = 1'b1;
                        ld_addr  = CFG_A;
                        ld_wdata = drop_bit(rd_word, FLAG_BIT);
                        ph_n     = PH_WR_CFG;
                    end else begin
                        done_n = 1'b1;
                        ph_n   = PH_IDLE;
                    end
                end
                PH_WR_CFG: begin
                    acc_clr = 1'b1;
                    sum_a_n = '0;
                    ld      = 1'b1;
                    ld_addr = '0;
                    ph_n    = PH_RD_SUM;
                end
                PH_RD_SUM: begin
                    acc_add = 1'b1;
                    ld      = 1'b1;
                    if (sum_a == END_A) begin
                        ld_addr = LAST_A;
                        ph_n    = PH_RD_OLD;
                    end else begin
                        sum_a_n = sum_a + 1'b1;
                        ld_addr = sum_a + 1'b1;
                    end
                end
                PH_RD_OLD: begin
                    res_n.old_ck = rd_word;
                    res_n.new_ck = acc_seal;
                    ld           = 1'b1;
                    ld_we        = 1'b1;
                    ld_addr      = LAST_A;
                    ld_wdata     = acc_seal;
                    ph_n         = PH_WR_CK;
                end
                PH_WR_CK: begin
                    res_n.patched = 1'b1;
                    done_n        = 1'b1;
                    ph_n          = PH_IDLE;
                end
                default: ph_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            res   <= '0;
            done  <= 1'b0;
            sum_a <= '0;
        end else begin
            ph    <= ph_n;
            res   <= res_n;
            done  <= done_n;
            sum_a <= sum_a_n;
        end
    end

    assign patched   = res.patched;
    assign error     = res.error;
    assign old_cksum = res.old_ck;
    assign new_cksum = res.new_ck;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width");  // R10
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_err |=> done && error && !patched) else $error("abort");  // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ph == PH_IDLE |-> !mem_req) else $error("req while idle");  // R8
    AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr == CFG_A |-> !mem_wdata[FLAG_BIT]) else $error("flag kept");  // R4
    AST_SEAL_MATCH: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr == LAST_A |-> mem_wdata == new_cksum) else $error("seal mismatch");  // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        start && ph != PH_IDLE && ph != PH_RD_CFG |=> ph != PH_RD_CFG) else $error("restart");  // R9
endmodule

// File: tb/eep_patch_seq_test.sv
module eep_patch_seq_test;
    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic [15:0]   mem_rdata = '0;
    logic          done, patched, error;
    logic [15:0]   old_cksum, new_cksum;

    eep_patch_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .done(done), .patched(patched),
        .error(error), .old_cksum(old_cksum), .new_cksum(new_cksum)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural word port
    logic [15:0] mem [N];
    int acc_cnt = 0, wr_cnt = 0, err_at = 0, wait_cnt = 0;
    logic [AW-1:0] first_addr = '0;
    logic          first_we = 1'b0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (!rst && mem_req && !mem_ack) begin
            if (wait_cnt >= acc_cnt % 3) begin
                wait_cnt = 0;
                acc_cnt++;
                mem_ack <= 1'b1;
                if (acc_cnt == 1) begin
                    first_addr = mem_addr;
                    first_we   = mem_we;
                end
                if (acc_cnt == err_at) begin
                    mem_err <= 1'b1;
                end else if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= mem[mem_addr];
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // scoreboard
    typedef struct packed {
        logic        p;
        logic        e;
        logic [15:0] o;
        logic [15:0] n;
    } exp_t;
    exp_t q[$];
    int done_cnt = 0;

    always @(negedge clk) begin
        if (done) begin
            exp_t x;
            done_cnt++;
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'(done_cnt), 0);
            end else begin
                x = q.pop_front();
                chk(patched == x.p, "R6 patched", 32'(patched), 32'(x.p));
                chk(error == x.e, "R8 error", 32'(error), 32'(x.e));
                chk(old_cksum == x.o, "R6 old_cksum", 32'(old_cksum), 32'(x.o));
                chk(new_cksum == x.n, "R5 new_cksum", 32'(new_cksum), 32'(x.n));
            end
        end
    end

    task automatic fill(input logic [15:0] seed, input logic [15:0] step);
        for (int i = 0; i < N; i++) mem[i] = seed + 16'(i) * step;
    endtask

    task automatic run_case(input int e_at, input bit poke);
        logic [15:0] img [N];
        exp_t        x;
        int          e_acc, d0, guard;
        logic [15:0] s;
        logic [15:0] sum_all;
        for (int i = 0; i < N; i++) img[i] = mem[i];
        x = '0;
        if (img[10][1]) begin
            s = '0;
            for (int i = 0; i < N - 1; i++)
                s = s + ((i == 10) ? (img[i] & 16'hFFFD) : img[i]);
            x.p = 1'b1;
            x.o = img[N-1];
            x.n = 16'hBABA - s;
            e_acc = N + 3;
        end else begin
            e_acc = 1;
        end
        if (e_at > 0 && e_at <= e_acc) begin
            x = '0;
            x.e = 1'b1;
            e_acc = e_at;
        end
        q.push_back(x);
        err_at = e_at; acc_cnt = 0; wr_cnt = 0; wait_cnt = 0;
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (done_cnt == d0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 one done per run", 32'(done_cnt - d0), 1);
        chk(acc_cnt == e_acc, "R7 access count", 32'(acc_cnt), 32'(e_acc));
        chk(first_addr == AW'(10) && !first_we, "R2 first access", 32'(first_addr), 10);
        chk(!mem_req, "R8 quiet after end", 32'(mem_req), 0);
        chk(patched == x.p && new_cksum == x.n, "R10 results held",
            32'(new_cksum), 32'(x.n));
        if (x.e) begin
            chk(mem[N-1] == img[N-1], "R8 seal untouched", 32'(mem[N-1]), 32'(img[N-1]));
        end else if (x.p) begin
            chk(mem[10] == (img[10] & 16'hFFFD), "R4 cfg word", 32'(mem[10]),
                32'(img[10] & 16'hFFFD));
            sum_all = '0;
            for (int i = 0; i < N; i++) sum_all = sum_all + mem[i];
            chk(sum_all == 16'hBABA, "R5 image sum", 32'(sum_all), 32'hBABA);
            chk(wr_cnt == 2, "R5 write count", 32'(wr_cnt), 2);
        end else begin
            chk(wr_cnt == 0, "R3 no write", 32'(wr_cnt), 0);
            chk(mem[10] == img[10], "R3 cfg untouched", 32'(mem[10]), 32'(img[10]));
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        fill(16'h1234, 16'h0F1D);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_req && !patched && !error, "R1 reset ctl", 32'(done), 0);
        chk(old_cksum == 0 && new_cksum == 0, "R1 reset cksum", 32'(new_cksum), 0);

        mem[10] = mem[10] | 16'h0002;
        run_case(0, 1'b0);             // R4 R5 R6 patch
        run_case(0, 1'b0);             // R3 already clear
        for (int i = 0; i < N; i++) mem[i] = 16'hFFFF;
        run_case(0, 1'b0);             // R5 wrap
        fill(16'hA5A5, 16'h0321);
        mem[10] = mem[10] | 16'h0002;
        run_case(0, 1'b1);             // R9 start mid-run
        mem[10] = mem[10] | 16'h0002;
        run_case(1, 1'b0);             // R8 error on first read
        run_case(40, 1'b0);            // R8 error during summing
        run_case(0, 1'b0);             // recovery after abort
        chk(q.size() == 0, "R10 scoreboard drained", 32'(q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule